// File: doc/BRIEF.md
# Quad 8-Bit DAC Serial Front End

This block is the digital side of a four-channel, 8-bit voltage-output converter. A host writes 12-bit frames over a three-wire serial port made of a select line, a serial clock and a data line. Each frame carries a 4-bit command followed by an 8-bit value, most significant bit first. The block keeps two register stages per channel. The first stage is a holding register that the serial port writes. The second stage is the code register that drives the converter, and it is the one presented at the `dac_code` output. Commands can fill a holding register alone, fill it and move all holding registers to the code stage in the same frame, or move them without loading anything. Further commands raise a low-power flag and set a general-purpose logic output.

All four serial and control pins are oversampled in the system clock domain. Data is taken on rising serial clock edges and `ser_out` changes on falling edges, so the port works in SPI modes 0 and 3 and another device can be chained behind it. A command takes effect when select rises, and only if exactly 12 clocks arrived in the frame. Any longer or shorter frame passes through and changes nothing. Two active-low level pins act outside the frame protocol. One copies every holding register into its code register. The other wipes all registers and the control outputs.

Top module: `qdac_front`

## Requirements
- R1: After reset, `dac_code` is all zero and `shdn`, `gp_out` and `ser_out` are 0.
- R2: A 12-bit frame with command 0001, 0010, 0011 or 0100 (frame bits 11:8) loads bits 7:0 into the holding register of channel A, B, C or D. Channel A is `dac_code[7:0]` and D is `dac_code[31:24]`. `dac_code` does not change.
- R3: Commands 1001 to 1100 load channel A to D the same way, and in the same update copy every holding register, including the newly written value, into the code stage.
- R4: Command 1000 copies all four holding registers into the code stage. Its data bits are ignored.
- R5: Command 1110 sets `shdn` to 1 and leaves every register unchanged. Any command from 0001 to 0100 or from 1000 to 1100 clears `shdn`.
- R6: Command 1111 sets `gp_out` to data bit 0 of the frame.
- R7: A frame whose clock count is not exactly 12 changes no register or output except `ser_out`. Command 0000 and the unused codes 0101, 0110, 0111 and 1101 change nothing.
- R8: `ser_out` changes only after a falling serial clock edge while selected, and it presents the bit shifted out of the 12-bit register. The value seen at the 13th to 24th rising edge of a frame is the frame's first 12 bits, in order.
- R9: While `xfer_n` is low, every code register takes the value of its holding register.
- R10: While `zero_n` is low, all holding and code registers, `shdn` and `gp_out` are forced to 0. This takes priority over `xfer_n` and over serial commands.
- R11: Frames are accepted in both serial clock idle polarities (SPI mode 0 with clock idling low, mode 3 with clock idling high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all pins |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock |
| ser_in | input | 1 | Serial data, taken on rising serial clock edges |
| xfer_n | input | 1 | Active-low level: copy all holding registers to code registers |
| zero_n | input | 1 | Active-low level: wipe all registers and control outputs |
| ser_out | output | 1 | Chained serial data, updated on falling serial clock edges |
| dac_code | output | 32 | Four 8-bit code registers, channel A in the low byte |
| shdn | output | 1 | Software low-power flag |
| gp_out | output | 1 | Software-set logic output |

## Verification
The holding registers cannot be seen at the ports, so any check of an input-only load (or of an ignored frame) is followed by a transfer command or an `xfer_n` pulse that exposes them through `dac_code`. The pass-through case is the hardest to reach. It needs an over-long 24-clock frame whose leading word is a valid command. The bench records `ser_out` at every rising edge and must then show both the replayed first word on the chain output and the absence of any register change once select rises.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CHANS  = 4;
  localparam int CTRL_W = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_LOAD_UPD,
    OP_UPD,
    OP_SHDN,
    OP_GPO
  } op_e;

  // Map a control nibble to an operation class
  function automatic op_e op_of(input logic [CTRL_W-1:0] code);
    op_e r;
    case (code)
      4'h1, 4'h2, 4'h3, 4'h4: r = OP_LOAD;
      4'h9, 4'hA, 4'hB, 4'hC: r = OP_LOAD_UPD;
      4'h8:                   r = OP_UPD;
      4'hE:                   r = OP_SHDN;
      4'hF:                   r = OP_GPO;
      default:                r = OP_NONE;
    endcase
    return r;
  endfunction

  // Channel index for load codes: low three bits minus one
  function automatic logic [$clog2(CHANS)-1:0] chan_of(input logic [CTRL_W-1:0] code);
    logic [2:0] t;
    t = code[2:0] - 3'd1;
    return t[$clog2(CHANS)-1:0];
  endfunction

  // Load or update commands end the low-power state
  function automatic logic wakes(input op_e op);
    return (op == OP_LOAD) || (op == OP_LOAD_UPD) || (op == OP_UPD);
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n_s,
  input  logic          sclk_s,
  input  logic          din_s,
  output logic [FW-1:0] frame,
  output logic          frame_done,
  output logic          sel_rise,
  output logic          rise_evt,
  output logic          fall_evt,
  output logic          ser_out
);
  localparam int CNTW = $clog2(FW + 2);
  localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(FW + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(FW);

  logic           sel_q, sclk_q;
  logic [CNTW-1:0] cnt;
  logic           sel_fall;
  logic           active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_n_s;
      sclk_q <= sclk_s;
    end
  end

  assign sel_fall = sel_q && !sel_n_s;
  assign sel_rise = !sel_q && sel_n_s;
  assign active   = !sel_n_s && !sel_q;
  assign rise_evt = active && !sclk_q && sclk_s;
  assign fall_evt = active && sclk_q && !sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      cnt   <= '0;
    end else if (sel_fall) begin
      cnt <= '0;
    end else if (rise_evt) begin
      frame <= {frame[FW-2:0], din_s};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_out <= 1'b0;
    else if (fall_evt) ser_out <= frame[FW-1];
  end

  assign frame_done = sel_rise && (cnt == CNT_FULL);
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   zero_act,
  input  logic                   xfer_act,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic                   upd_all,
  output logic [NCH*DW-1:0]      in_flat,
  output logic [NCH*DW-1:0]      dac_flat
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] hold_r, code_r;
      logic          hit;
      assign hit = wr_en && (wr_idx == c[$clog2(NCH)-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_r <= '0;
        else if (zero_act) hold_r <= '0;
        else if (hit)      hold_r <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         code_r <= '0;
        else if (zero_act)  code_r <= '0;
        else if (upd_all)   code_r <= hit ? wr_data : hold_r;
        else if (xfer_act)  code_r <= hold_r;
      end

      assign in_flat[c*DW +: DW]  = hold_r;
      assign dac_flat[c*DW +: DW] = code_r;
    end
  endgenerate
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_sel_n,
  input  logic                ser_clk,
  input  logic                ser_in,
  input  logic                xfer_n,
  input  logic                zero_n,
  output logic                ser_out,
  output logic [CHANS*DW-1:0] dac_code,
  output logic                shdn,
  output logic                gp_out
);
  localparam int FW = CTRL_W + DW;
  localparam int IW = $clog2(CHANS);

  logic [4:0] pins_s;
  logic sel_n_s, sclk_s, din_s, xfer_s, zero_s;

  qdac_sync #(.W(5), .STAGES(SYNC), .RST_VAL(5'b10011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_sel_n, ser_clk, ser_in, xfer_n, zero_n}),
    .q(pins_s)
  );
  assign {sel_n_s, sclk_s, din_s, xfer_s, zero_s} = pins_s;

  logic [FW-1:0] frame;
  logic frame_done, sel_rise, rise_evt, fall_evt;

  qdac_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(sel_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .frame(frame), .frame_done(frame_done), .sel_rise(sel_rise),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .ser_out(ser_out)
  );

  // Named decode events
  op_e           op;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          zero_act, xfer_act, wr_evt, upd_cmd, upd_evt;
  logic          shdn_cmd, gpo_cmd, wake_cmd;

  assign op       = op_of(frame[FW-1 -: CTRL_W]);
  assign wr_idx   = chan_of(frame[FW-1 -: CTRL_W]);
  assign wr_data  = frame[DW-1:0];
  assign zero_act = !zero_s;
  assign xfer_act = !xfer_s;
  assign wr_evt   = frame_done && ((op == OP_LOAD) || (op == OP_LOAD_UPD));
  assign upd_cmd  = frame_done && ((op == OP_LOAD_UPD) || (op == OP_UPD));
  assign upd_evt  = upd_cmd || xfer_act;
  assign shdn_cmd = frame_done && (op == OP_SHDN);
  assign gpo_cmd  = frame_done && (op == OP_GPO);
  assign wake_cmd = frame_done && wakes(op);

  logic [CHANS*DW-1:0] in_flat;

  qdac_bank #(.NCH(CHANS), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .zero_act(zero_act), .xfer_act(xfer_act),
    .wr_en(wr_evt), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_all(upd_cmd),
    .in_flat(in_flat), .dac_flat(dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn   <= 1'b0;
      gp_out <= 1'b0;
    end else if (zero_act) begin
      shdn   <= 1'b0;
      gp_out <= 1'b0;
    end else begin
      if (shdn_cmd)      shdn <= 1'b1;
      else if (wake_cmd) shdn <= 1'b0;
      if (gpo_cmd)       gp_out <= wr_data[0];
    end
  end
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int NB = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zero_act,
  input logic          upd_evt,
  input logic          wr_evt,
  input logic          shdn_cmd,
  input logic          gpo_cmd,
  input logic          fall_evt,
  input logic [NB-1:0] dac_code,
  input logic [NB-1:0] in_flat,
  input logic          shdn,
  input logic          gp_out,
  input logic          ser_out
);
  // R10: wipe clears everything on the next edge
  a_r10_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    zero_act |=> (dac_code == '0 && in_flat == '0 && !shdn && !gp_out));

  // R4 / R9: code stage moves only on an update event
  a_r4_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !zero_act) |=> $stable(dac_code));

  // R2: holding stage moves only on a load command
  a_r2_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !zero_act) |=> $stable(in_flat));

  // R5: low-power flag rises only after its command
  a_r5_shdn_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn) |-> $past(shdn_cmd));

  // R6: logic output changes only after its command or a wipe
  a_r6_gp_src: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gp_out) |-> $past(gpo_cmd || zero_act));

  // R8: chain output moves only after a falling serial edge
  a_r8_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(ser_out));
endmodule

bind qdac_front qdac_front_chk #(.NB(qdac_pkg::CHANS*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .zero_act(zero_act), .upd_evt(upd_evt),
  .wr_evt(wr_evt), .shdn_cmd(shdn_cmd), .gpo_cmd(gpo_cmd), .fall_evt(fall_evt),
  .dac_code(dac_code), .in_flat(in_flat), .shdn(shdn), .gp_out(gp_out),
  .ser_out(ser_out)
);

// File: tb/qdac_front_test.sv
module qdac_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0;
  logic xfer_n = 1'b1, zero_n = 1'b1;
  logic ser_out, shdn, gp_out;
  logic [31:0] dac_code;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] m_in [4];
  logic [7:0] m_dac [4];
  logic m_sd = 0, m_gp = 0;
  logic cap [64];

  always #10 clk = ~clk;

  qdac_front uut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_in(ser_in), .xfer_n(xfer_n), .zero_n(zero_n), .ser_out(ser_out),
    .dac_code(dac_code), .shdn(shdn), .gp_out(gp_out)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_pack();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  task automatic chk_state(input string req);
    chk({req, " code"}, dac_code, m_pack());
    chk({req, " shdn"}, {31'd0, shdn}, {31'd0, m_sd});
    chk({req, " gp"}, {31'd0, gp_out}, {31'd0, m_gp});
  endtask

  // Independent command model
  task automatic model(input logic [11:0] w);
    logic [3:0] c;
    logic [7:0] d;
    c = w[11:8];
    d = w[7:0];
    if (c >= 4'd1 && c <= 4'd4) begin
      m_in[c - 4'd1] = d; m_sd = 0;
    end else if (c >= 4'd9 && c <= 4'd12) begin
      m_in[c - 4'd9] = d; m_sd = 0;
      for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    end else if (c == 4'd8) begin
      m_sd = 0;
      for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    end else if (c == 4'd14) m_sd = 1;
    else if (c == 4'd15) m_gp = d[0];
  endtask

  // Send n bits of w, MSB first; m3 selects clock idling high
  task automatic send(input logic [31:0] w, input int n, input bit m3);
    ser_clk = m3;
    wait_clk(8);
    ser_sel_n = 1'b0;
    wait_clk(6);
    for (int k = 0; k < n; k++) begin
      if (m3) ser_clk = 1'b0;
      ser_in = w[n-1-k];
      wait_clk(6);
      cap[k] = ser_out;
      ser_clk = 1'b1;
      wait_clk(6);
      if (!m3) ser_clk = 1'b0;
    end
    wait_clk(6);
    ser_sel_n = 1'b1;
    wait_clk(10);
    if (n == 12) model(w[11:0]);
  endtask

  task automatic t_reset();
    chk_state("R1 reset");
    chk("R1 ser_out", {31'd0, ser_out}, 32'd0);
  endtask

  task automatic t_load_only();
    send(32'h15A, 12, 0); send(32'h23C, 12, 0);
    send(32'h3C3, 12, 0); send(32'h481, 12, 0);
    chk_state("R2 load only");
    send(32'h8FF, 12, 0);
    chk_state("R4 transfer");
  endtask

  task automatic t_load_upd();
    send(32'hB77, 12, 1);
    chk_state("R3 R11 load+update mode3");
    send(32'h1E4, 12, 1);
    send(32'h8AA, 12, 1);
    chk_state("R11 mode3 transfer");
  endtask

  task automatic t_shdn();
    send(32'hE55, 12, 0);
    chk_state("R5 shutdown set");
    send(32'h266, 12, 0);
    chk_state("R5 load clears shutdown");
    send(32'hE00, 12, 0);
    send(32'h800, 12, 0);
    chk_state("R5 transfer clears shutdown");
  endtask

  task automatic t_gpo();
    send(32'hF01, 12, 0);
    chk_state("R6 gp set");
    send(32'hFFE, 12, 1);
    chk_state("R6 gp clear");
  endtask

  task automatic t_bad_frames();
    send(32'h4CC, 11, 0);
    send(32'h1999, 13, 0);
    send(32'h0AB, 12, 0);
    send(32'h5AB, 12, 0);
    send(32'hDAB, 12, 0);
    chk_state("R7 ignored frames");
    send(32'h800, 12, 0);
    chk_state("R7 holding untouched");
  endtask

  task automatic t_daisy();
    logic [11:0] got;
    send(32'h912345, 24, 0);
    for (int k = 0; k < 12; k++) got[11-k] = cap[12+k];
    chk("R8 chain replay mode0", {20'd0, got}, 32'h912);
    chk_state("R7 pass-through no change");
    send(32'hF01A5E, 24, 1);
    for (int k = 0; k < 12; k++) got[11-k] = cap[12+k];
    chk("R8 chain replay mode3", {20'd0, got}, 32'hF01);
    chk_state("R7 pass-through mode3");
  endtask

  task automatic t_xfer_pin();
    send(32'h111, 12, 0);
    send(32'h4EE, 12, 0);
    chk_state("R9 before pulse");
    xfer_n = 1'b0; wait_clk(10); xfer_n = 1'b1; wait_clk(6);
    for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    chk_state("R9 pin transfer");
  endtask

  task automatic t_zero();
    send(32'hF01, 12, 0);
    send(32'hE00, 12, 0);
    send(32'h2F0, 12, 0);
    xfer_n = 1'b0; zero_n = 1'b0; wait_clk(10);
    zero_n = 1'b1; xfer_n = 1'b1; wait_clk(6);
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_dac[i] = 0; end
    m_sd = 0; m_gp = 0;
    chk_state("R10 wipe");
    send(32'h800, 12, 0);
    chk_state("R10 holding wiped");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_dac[i] = 0; end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_load_only();
    t_load_upd();
    t_shdn();
    t_gpo();
    t_bad_frames();
    t_daisy();
    t_xfer_pin();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule